// File: doc/BRIEF.md
# Single-Channel Memory-to-Stream DMA

This block is one DMA channel driven by a processor through three word-sized registers. Software loads a source address and a word count. It then sets the start bit in the control register. The channel reads that many 32-bit words from a memory read port. The memory port has a request side (enable plus address) and a response side (data plus its own valid strobe) that arrives one or more cycles later. Each word is presented in memory order on an output stream with valid/ready handshaking, and the final word carries a last flag.

When a transfer finishes, the channel produces a one-cycle completion pulse. This pulse is meant to be latched by a separate interrupt controller. At the same time the busy output drops and a free-running count of completed transfers advances. The stream follows the usual back-pressure rules. A beat moves only in a cycle where both valid and ready are high. While valid is high and ready is low, data and last are held unchanged. The channel never withdraws valid before the beat is taken. Only one memory request is outstanding at any time. The next request is issued only after the previous word has left on the stream.

Top module: `dma_stream_channel`

## Requirements
- R1: After reset, busy, completion and stream valid are low, the completed-transfer count is 0, and all three registers read 0.
- R2: Register offsets are 0x0 for the source address, 0x4 for the word count and 0x8 for control. A read returns its value with read-valid high in the cycle after the read enable, and an unused offset reads 0.
- R3: A control write with bit 0 set while idle starts a transfer from the current address and count. Busy is high from the next cycle, control bit 0 reads 1 while busy and 0 once the channel is idle again.
- R4: Memory reads are issued at the source address and then at each following address 4 higher. There is never more than one request outstanding, and a response is accepted after any latency of one cycle or more.
- R5: Words leave in memory order. One word moves per cycle in which valid and ready are both high, and data and last hold steady while valid waits on ready.
- R6: The last flag is high on the final word of a transfer and low on every other word.
- R7: The completion output is high for exactly one cycle, in the cycle after the final word is taken. Busy is low in the cycle after that.
- R8: The completed-transfer count rises by one per completed transfer, in the cycle after the completion pulse.
- R9: A start with a word count of 0 raises the completion pulse in the cycle after the control write. It produces no memory reads and no stream words.
- R10: While busy, writes to any register are ignored. The address and count are left alone, and a second start neither restarts the channel nor adds words.
- R11: The address register reads the next fetch address and the count register reads the number of words not yet taken by the stream. After a transfer of N words they read start+4N and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_off | input | OFF_W | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 32 | Memory read response data |
| mem_rd_valid | input | 1 | Memory read response strobe |
| m_valid | output | 1 | Stream word valid |
| m_data | output | 32 | Stream word |
| m_last | output | 1 | Final word of the transfer |
| m_ready | input | 1 | Stream sink ready |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |
| done_count_o | output | DONE_W | Completed-transfer count |

## Verification
The bench drives the stream sink with ready held high, with ready toggled by a pseudo-random pattern, and with ready held low for long stretches. A channel that let data change under a stalled beat, or that dropped or duplicated a word, would put out a word stream that does not match the scoreboard. Memory latency rotates between one and four cycles, so a design that assumed a fixed response time would capture stale data. A zero word count is tried: a channel that counted down through zero would fetch thousands of words instead of finishing at once. A transfer is also stalled midway while its registers are rewritten and the start bit is set again. A design that did not lock its registers would then change the address, or restart and emit extra words, or bump the completed count twice.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SEND,
    ST_FIN
  } eng_state_e;

  localparam logic [3:0] OFF_SRC   = 4'h0;
  localparam logic [3:0] OFF_WORDS = 4'h4;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam int         GO_BIT    = 0;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_rd_valid,
  input  logic              busy_i,
  input  logic              adv_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_open;
  logic [DATA_W-1:0] rd_mux;

  assign wr_open = reg_wr_en && !busy_i;
  assign start_o = wr_open && (reg_off == OFF_W'(OFF_CTRL)) && reg_wr_data[GO_BIT];
  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (adv_i)
        addr_q <= addr_q + STEP;
      else if (wr_open && reg_off == OFF_W'(OFF_SRC))
        addr_q <= reg_wr_data[ADDR_W-1:0];
      if (dec_i)
        cnt_q <= cnt_q - CNT_W'(1);
      else if (wr_open && reg_off == OFF_W'(OFF_WORDS))
        cnt_q <= reg_wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    case (reg_off)
      OFF_W'(OFF_SRC):   rd_mux = DATA_W'(addr_q);
      OFF_W'(OFF_WORDS): rd_mux = DATA_W'(cnt_q);
      OFF_W'(OFF_CTRL):  rd_mux = DATA_W'(busy_i);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_data  <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) reg_rd_data <= rd_mux;
    end
  end

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);
  a_r10_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !adv_i) |=> $stable(addr_q));
  a_r10_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  input  logic              m_ready,
  output logic              adv_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic              done_o
);
  eng_state_e        state, state_n;
  logic [DATA_W-1:0] data_q;
  logic              final_word;

  assign final_word = (cnt_i == CNT_W'(1));

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (start_i) state_n = (cnt_i == '0) ? ST_FIN : ST_REQ;
      ST_REQ:  state_n = ST_WAIT;
      ST_WAIT: if (mem_rd_valid) state_n = ST_SEND;
      ST_SEND: if (m_ready) state_n = final_word ? ST_FIN : ST_REQ;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
    end else begin
      state <= state_n;
      if (state == ST_WAIT && mem_rd_valid) data_q <= mem_rd_data;
    end
  end

  assign mem_rd_en   = (state == ST_REQ);
  assign mem_rd_addr = addr_i;
  assign adv_o       = (state == ST_REQ);
  assign m_valid     = (state == ST_SEND);
  assign m_data      = data_q;
  assign m_last      = (state == ST_SEND) && final_word;
  assign dec_o       = (state == ST_SEND) && m_ready;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FIN);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  a_r4_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> done_o);
endmodule

// File: rtl/dma_done_counter.sv
module dma_done_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else if (done_i) count_o <= count_o + W'(1);
  end

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (count_o == W'($past(count_o) + W'(1))));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(count_o));
endmodule

// File: rtl/dma_stream_channel.sv
module dma_stream_channel #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DONE_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  output logic              reg_rd_valid,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              m_valid,
  output logic [31:0]       m_data,
  output logic              m_last,
  input  logic              m_ready,
  output logic              done_o,
  output logic              busy_o,
  output logic [DONE_W-1:0] done_count_o
);
  localparam int WORD_W = 32;

  logic              start, adv, dec;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(WORD_W), .OFF_W(OFF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_off(reg_off),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .reg_rd_valid(reg_rd_valid),
    .busy_i(busy_o), .adv_i(adv), .dec_i(dec),
    .addr_o(addr), .cnt_o(cnt), .start_o(start)
  );

  dma_chan_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(WORD_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .addr_i(addr), .cnt_i(cnt),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
    .adv_o(adv), .dec_o(dec), .busy_o(busy_o), .done_o(done_o)
  );

  dma_done_counter #(.W(DONE_W)) u_done_cnt (
    .clk(clk), .rst_n(rst_n), .done_i(done_o), .count_o(done_count_o)
  );
endmodule

// File: tb/dma_stream_channel_tb.sv
`timescale 1ns/1ps
module dma_stream_channel_tb;
  logic        clk, rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [3:0]  reg_off;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        reg_rd_valid;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        mem_rd_valid;
  logic        m_valid, m_last, m_ready;
  logic [31:0] m_data;
  logic        done_o, busy_o;
  logic [15:0] done_count_o;

  dma_stream_channel u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_off(reg_off),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .reg_rd_valid(reg_rd_valid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
    .done_o(done_o), .busy_o(busy_o), .done_count_o(done_count_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mem_reads = 0;
  int ready_mode = 0;   // 0 always ready, 1 pseudo-random, 2 held low
  logic [31:0] exp_data[$];
  logic        exp_last[$];

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // memory model: latency rotates 1..4 cycles
  int pend = 0;
  int lat = 1;
  logic [31:0] paddr;
  initial begin mem_rd_valid = 1'b0; mem_rd_data = '0; end
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = word_at(paddr);
      end
    end
    if (rst_n && mem_rd_en) begin
      chk(pend == 0, "R4 outstanding", 32'(pend), 0);
      mem_reads++;
      paddr = mem_rd_addr;
      pend  = lat;
      lat   = (lat % 4) + 1;
    end
  end

  // stream sink and scoreboard monitor
  logic [7:0]  lfsr = 8'hA7;
  logic        pv = 0, pr = 0, pl = 0, pdone = 0;
  logic [31:0] pd = '0;
  initial m_ready = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(m_valid && m_data == pd && m_last == pl, "R5 stall hold", m_data, pd);
      if (done_o && pdone) chk(1'b0, "R7 pulse width", 2, 1);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[1] : 1'b0;
    if (rst_n && m_valid && m_ready) begin
      if (exp_data.size() == 0) chk(1'b0, "R5 unexpected word", m_data, 0);
      else begin
        logic [31:0] ed;
        logic el;
        ed = exp_data.pop_front();
        el = exp_last.pop_front();
        chk(m_data == ed, "R5 word order", m_data, ed);
        chk(m_last == el, "R6 last flag", 32'(m_last), 32'(el));
      end
    end
    pv = m_valid; pr = m_ready; pd = m_data; pl = m_last; pdone = done_o;
  end

  task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_off = off; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_off = off;
    @(negedge clk);
    chk(reg_rd_valid, "R2 read valid", 32'(reg_rd_valid), 1);
    d = reg_rd_data;
    reg_rd_en = 1'b0;
  endtask

  task automatic run_xfer(input logic [31:0] a, input int n, input int mode,
                          input bit poke, input logic [15:0] exp_done);
    logic [31:0] v;
    int r0;
    int w;
    ready_mode = mode;
    reg_write(4'h0, a);
    reg_write(4'h4, 32'(n));
    for (int i = 0; i < n; i++) begin
      exp_data.push_back(word_at(a + 32'(4 * i)));
      exp_last.push_back(i == n - 1);
    end
    r0 = mem_reads;
    reg_write(4'h8, 32'h1);
    chk(busy_o, "R3 busy after start", 32'(busy_o), 1);
    if (n == 0) begin
      chk(done_o, "R9 immediate completion", 32'(done_o), 1);
    end
    if (poke) begin
      repeat (8) @(negedge clk);
      reg_write(4'h0, 32'h0000_0990);
      reg_write(4'h4, 32'd2);
      reg_write(4'h8, 32'h1);
      reg_read(4'h0, v);
      chk(v == a + 4, "R10 address locked / R11 next fetch", v, a + 4);
      reg_read(4'h4, v);
      chk(v == 32'(n), "R10 count locked / R11 remaining", v, 32'(n));
      reg_read(4'h8, v);
      chk(v == 32'h1, "R3 control reads busy", v, 1);
      ready_mode = 0;
    end
    w = 0;
    while (!done_o && w < 3000) begin @(negedge clk); w++; end
    chk(done_o, "R7 completion seen", 32'(done_o), 1);
    chk(exp_data.size() == 0, "R7 all words before pulse", 32'(exp_data.size()), 0);
    @(negedge clk);
    chk(!done_o && !busy_o, "R7 pulse ends and busy falls", {30'd0, done_o, busy_o}, 0);
    chk(done_count_o == exp_done, "R8 done count", 32'(done_count_o), 32'(exp_done));
    chk(mem_reads - r0 == n, "R4 R9 R10 memory reads", 32'(mem_reads - r0), 32'(n));
    reg_read(4'h0, v);
    chk(v == a + 32'(4 * n), "R11 final address", v, a + 32'(4 * n));
    reg_read(4'h4, v);
    chk(v == 0, "R11 final count", v, 0);
    reg_read(4'h8, v);
    chk(v == 0, "R3 start bit self-clears", v, 0);
    repeat (5) @(negedge clk);
    chk(done_count_o == exp_done && !busy_o, "R10 no second transfer",
        32'(done_count_o), 32'(exp_done));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_off = '0; reg_wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !m_valid, "R1 outputs idle",
        {29'd0, busy_o, done_o, m_valid}, 0);
    chk(done_count_o == 0, "R1 done count", 32'(done_count_o), 0);
    reg_read(4'h0, v); chk(v == 0, "R1 address", v, 0);
    reg_read(4'h4, v); chk(v == 0, "R1 count", v, 0);
    reg_read(4'h8, v); chk(v == 0, "R1 control", v, 0);
    reg_read(4'hC, v); chk(v == 0, "R2 unused offset", v, 0);
    reg_write(4'h0, 32'h0000_1230);
    reg_read(4'h0, v); chk(v == 32'h0000_1230, "R2 address readback", v, 32'h1230);

    run_xfer(32'h0000_1000, 1, 0, 1'b0, 16'd1);
    run_xfer(32'h0000_2000, 5, 1, 1'b0, 16'd2);
    run_xfer(32'h0000_3000, 0, 0, 1'b0, 16'd3);
    run_xfer(32'h0000_4000, 6, 2, 1'b1, 16'd4);
    run_xfer(32'h0000_5000, 8, 1, 1'b0, 16'd5);
    run_xfer(32'hFFFF_FFF0, 3, 0, 1'b0, 16'd6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule